// File: doc/BRIEF.md
# Divider Setting Shadow and Commit Controller

This block keeps the feedback divider settings of a digital PLL: an integer part, a fractional numerator and a modulus. Each is 32 bits wide and is written one byte at a time over a simple byte-wide register bus. Bus writes land only in shadow registers. The divider outputs that the loop uses change only after software writes the commit code to the update address.

When a commit is applied, the block compares the committed set with the set that is active. If the integer part and the modulus are unchanged, the new fraction is applied on a sample tick and the loop keeps running. If either the integer part or the modulus changed, the block raises a holdover request for a programmable number of phase-detector sample ticks. The new settings are loaded into the active outputs halfway through that window. The request then drops by itself.

A commit that arrives while a holdover window is open waits in a one-deep queue. It is applied after the window closes. If several commits arrive while it waits, the latest one replaces the earlier ones.

Top module: `div_update_ctrl`

## Requirements
- R1: After reset, all shadow bytes and all active outputs are zero, `holdover_o` is low, and the hold-length register at address 0x0010 reads 4.
- R2: Byte b (0..3, where byte 0 is bits 7:0) of the fraction is at address 0x0000+b, of the integer part at 0x0004+b, and of the modulus at 0x0008+b. A write stores into that shadow byte, and a read returns the shadow byte. Address 0x000F reads 0, and address 0x0010 reads the hold length.
- R3: Shadow writes alone never change `frac_o`, `n_o` or `mod_o`.
- R4: Only a write of exactly 0x01 to address 0x000F commits. Any other value written there has no effect.
- R5: A commit whose integer part and modulus equal the active ones updates `frac_o` on the first sample tick that comes at least two clocks after the commit write. `holdover_o` is not raised.
- R6: A commit that changes the integer part or the modulus raises `holdover_o` on its applying tick. `holdover_o` stays high for exactly L further ticks and falls on the L-th tick, where L is the hold length captured when the window starts.
- R7: In that window, all three active outputs take the committed values on tick ceil(L/2) of the window, and at no other time.
- R8: A commit made while `holdover_o` is high is held and applied on a tick after the window ends. If several commits are made in that time, only the last one is applied.
- R9: A hold length of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for one clock |
| bus_addr_i | input | 16 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i` (combinational) |
| tick_i | input | 1 | Phase-detector sample tick |
| frac_o | output | 32 | Active fractional numerator |
| n_o | output | 32 | Active integer part |
| mod_o | output | 32 | Active modulus |
| holdover_o | output | 1 | Holdover request to the loop |

## Verification
A pending commit that is lost or stuck in the queue shows as an active output that keeps its old value one tick past the point where it should change. A wrong change classification shows as a `holdover_o` pulse that appears or is missing on the applying tick. A hold counter that is off by one moves the load tick or the falling edge of `holdover_o` by one tick, which is three clocks at the bench's tick rate. The bench compares every output against a behavioural model on every clock, so each of these faults is reported in the cycle where it first appears.

// File: rtl/div_upd_pkg.sv
package div_upd_pkg;
  localparam int unsigned FIELD_BYTES = 4;
  localparam int unsigned FIELD_W     = 8 * FIELD_BYTES;
  localparam int unsigned NUM_FIELDS  = 3;
  localparam int unsigned SET_BYTES   = NUM_FIELDS * FIELD_BYTES;

  typedef struct packed {
    logic [FIELD_W-1:0] modu;
    logic [FIELD_W-1:0] n;
    logic [FIELD_W-1:0] frac;
  } div_set_t;
endpackage

// File: rtl/div_shadow_regs.sv
module div_shadow_regs
  import div_upd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [15:0] UPD_ADDR = 16'h000F,
  parameter logic [15:0] LEN_ADDR = 16'h0010,
  parameter logic [7:0]  UPD_CODE = 8'h01,
  parameter logic [7:0]  LEN_DEF  = 8'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output div_set_t          shadow_o,
  output logic [DATA_W-1:0] hold_len_o,
  output logic              commit_o
);
  localparam logic [ADDR_W-1:0] UPD_A = ADDR_W'(UPD_ADDR);
  localparam logic [ADDR_W-1:0] LEN_A = ADDR_W'(LEN_ADDR);

  logic [DATA_W-1:0] byte_q [SET_BYTES];
  logic [DATA_W-1:0] len_q;
  logic              upd_q;

  for (genvar i = 0; i < SET_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                byte_q[i] <= '0;
      else if (wr_i && addr_i == ADDR_W'(i))      byte_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= DATA_W'(LEN_DEF);
      upd_q <= 1'b0;
    end else begin
      if (wr_i && addr_i == LEN_A) len_q <= wdata_i;
      // update bit self-clears after one cycle
      upd_q <= wr_i && addr_i == UPD_A && wdata_i == DATA_W'(UPD_CODE);
    end
  end

  always_comb begin
    for (int b = 0; b < FIELD_BYTES; b++) begin
      shadow_o.frac[8*b +: 8] = byte_q[b];
      shadow_o.n[8*b +: 8]    = byte_q[FIELD_BYTES + b];
      shadow_o.modu[8*b +: 8] = byte_q[2*FIELD_BYTES + b];
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < SET_BYTES; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = byte_q[i];
    if (addr_i == LEN_A) rdata_o = len_q;
  end

  assign hold_len_o = len_q;
  assign commit_o   = upd_q;
endmodule

// File: rtl/div_hold_timer.sv
module div_hold_timer #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             mid_o,
  output logic             done_o
);
  logic [LEN_W-1:0] len_q, cnt_q;
  logic             busy_q;
  logic [LEN_W:0]   cnt_nx, half;

  assign cnt_nx = {1'b0, cnt_q} + 1'b1;
  assign half   = ({1'b0, len_q} + 1'b1) >> 1;
  assign mid_o  = busy_q && tick_i && cnt_nx == half;
  assign done_o = busy_q && tick_i && cnt_nx == {1'b0, len_q};
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      len_q  <= (len_i == '0) ? LEN_W'(1) : len_i;
    end else if (busy_q && tick_i) begin
      cnt_q <= cnt_nx[LEN_W-1:0];
      if (done_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/div_commit_seq.sv
module div_commit_seq
  import div_upd_pkg::*;
#(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             commit_i,
  input  div_set_t         shadow_i,
  input  logic [LEN_W-1:0] hold_len_i,
  output div_set_t         active_o,
  output logic             holdover_o
);
  div_set_t pend_q, flight_q, act_q;
  logic     pend_v_q;
  logic     busy, mid, apply, nm_chg, start;

  assign nm_chg = (pend_q.n != act_q.n) || (pend_q.modu != act_q.modu);
  // a commit being captured this cycle waits for a later tick
  assign apply  = tick_i && pend_v_q && !commit_i && !busy;
  assign start  = apply && nm_chg;

  div_hold_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(start),
    .len_i  (hold_len_i),
    .busy_o (busy),
    .mid_o  (mid),
    .done_o ()
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      flight_q <= '0;
      act_q    <= '0;
    end else begin
      if (commit_i) begin
        pend_q   <= shadow_i;
        pend_v_q <= 1'b1;
      end else if (apply) begin
        pend_v_q <= 1'b0;
      end
      if (start) flight_q <= pend_q;
      if (apply && !nm_chg) act_q.frac <= pend_q.frac;
      if (mid) act_q <= flight_q;
    end
  end

  assign active_o   = act_q;
  assign holdover_o = busy;
endmodule

// File: rtl/div_update_ctrl.sv
module div_update_ctrl
  import div_upd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 8,
  parameter logic [15:0] UPD_ADDR = 16'h000F,
  parameter logic [15:0] LEN_ADDR = 16'h0010,
  parameter logic [7:0]  LEN_DEF  = 8'd4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic               tick_i,
  output logic [FIELD_W-1:0] frac_o,
  output logic [FIELD_W-1:0] n_o,
  output logic [FIELD_W-1:0] mod_o,
  output logic               holdover_o
);
  div_set_t          shadow, active;
  logic [DATA_W-1:0] hold_len;
  logic              commit;

  div_shadow_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .UPD_ADDR(UPD_ADDR),
    .LEN_ADDR(LEN_ADDR),
    .UPD_CODE(8'h01),
    .LEN_DEF (LEN_DEF)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .shadow_o  (shadow),
    .hold_len_o(hold_len),
    .commit_o  (commit)
  );

  div_commit_seq #(.LEN_W(DATA_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .commit_i  (commit),
    .shadow_i  (shadow),
    .hold_len_i(hold_len),
    .active_o  (active),
    .holdover_o(holdover_o)
  );

  assign frac_o = active.frac;
  assign n_o    = active.n;
  assign mod_o  = active.modu;
endmodule

// File: rtl/div_update_ctrl_chk.sv
module div_update_ctrl_chk
  import div_upd_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               holdover_o,
  input logic [FIELD_W-1:0] frac_o,
  input logic [FIELD_W-1:0] n_o,
  input logic [FIELD_W-1:0] mod_o
);
  assert_hold_rise_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(holdover_o) |-> $past(tick_i));

  assert_hold_fall_on_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(holdover_o) |-> $past(tick_i) && $past(holdover_o));

  assert_nm_change_in_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(n_o) || !$stable(mod_o)) |-> $past(holdover_o) && $past(tick_i));

  assert_frac_change_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frac_o) |-> $past(tick_i));
endmodule

bind div_update_ctrl div_update_ctrl_chk u_chk (.*);

// File: tb/div_update_ctrl_bench.sv
module div_update_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        tick_i = 1'b0;
  logic [31:0] frac_o, n_o, mod_o;
  logic        holdover_o;

  int n_chk = 0, n_err = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  div_update_ctrl u_div_update_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0]  m_bytes [12];
  logic [7:0]  m_len;
  bit          m_upd, m_hold;
  int          m_cnt, m_flen;
  logic [31:0] m_frac, m_n, m_mod;
  logic [95:0] m_fl;
  logic [95:0] m_q[$];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_bytes[i]) m_bytes[i] = '0;
      m_len = 8'd4; m_upd = 0; m_hold = 0; m_cnt = 0; m_flen = 1;
      m_frac = '0; m_n = '0; m_mod = '0; m_fl = '0; m_q.delete();
    end else begin
      logic [95:0] snap;
      bit go;
      for (int i = 0; i < 12; i++) snap[8*i +: 8] = m_bytes[i];
      go = tick_i && m_q.size() != 0 && !m_upd && !m_hold;
      if (m_hold && tick_i) begin
        m_cnt++;
        if (m_cnt == (m_flen + 1) / 2) {m_mod, m_n, m_frac} = m_fl;
        if (m_cnt == m_flen) m_hold = 0;
      end
      if (go) begin
        logic [95:0] p;
        p = m_q.pop_front();
        if (p[95:32] != {m_mod, m_n}) begin
          m_hold = 1; m_cnt = 0; m_fl = p;
          m_flen = (m_len == 0) ? 1 : int'(m_len);
        end else m_frac = p[31:0];
      end
      if (m_upd) begin m_q.delete(); m_q.push_back(snap); end
      m_upd = bus_wr_i && bus_addr_i == 16'h000F && bus_wdata_i == 8'h01;
      if (bus_wr_i && bus_addr_i < 16'd12) m_bytes[bus_addr_i[3:0]] = bus_wdata_i;
      if (bus_wr_i && bus_addr_i == 16'h0010) m_len = bus_wdata_i;
    end
  end

  // per-clock comparison and pulse measurement
  bit          h_prev = 0;
  logic [31:0] n_prev = '0, mod_prev = '0;
  int          pulse_ticks = 0, load_at = -1, rises = 0;

  always @(posedge clk_i) begin
    #1;
    if (rst_ni) begin
      logic [7:0] exp_rd;
      chk("R5 frac_o", frac_o, m_frac);
      chk("R7 n_o", n_o, m_n);
      chk("R7 mod_o", mod_o, m_mod);
      chk("R6 holdover_o", {31'd0, holdover_o}, {31'd0, m_hold});
      exp_rd = (bus_addr_i < 16'd12) ? m_bytes[bus_addr_i[3:0]] :
               (bus_addr_i == 16'h0010) ? m_len : 8'h00;
      chk("R2 bus_rdata_o", {24'd0, bus_rdata_o}, {24'd0, exp_rd});
      if (h_prev && tick_i) pulse_ticks++;
      if (!h_prev && holdover_o) begin rises++; pulse_ticks = 0; end
      if (n_o != n_prev || mod_o != mod_prev) load_at = pulse_ticks;
    end
    h_prev = holdover_o; n_prev = n_o; mod_prev = mod_o;
  end

  initial begin
    int k = 0;
    forever begin
      @(negedge clk_i);
      k = (k + 1) % 3;
      tick_i = (k == 0);
    end
  end

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a;
    @(posedge clk_i); #1;
    d = bus_rdata_o;
  endtask

  task automatic wait_pulse();
    @(posedge holdover_o);
    @(negedge holdover_o);
    repeat (2) @(posedge clk_i);
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int r0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R1 reset state
    chk("R1 frac_o", frac_o, 32'd0);
    chk("R1 n_o", n_o, 32'd0);
    chk("R1 mod_o", mod_o, 32'd0);
    chk("R1 holdover_o", {31'd0, holdover_o}, 32'd0);
    bus_rd(16'h0010, rd); chk("R1 hold length", {24'd0, rd}, 32'd4);
    bus_rd(16'h0005, rd); chk("R1 shadow n byte1", {24'd0, rd}, 32'd0);

    // R2 byte writes and readback
    bus_wr(16'h0000, 8'h11); bus_wr(16'h0001, 8'h22);
    bus_wr(16'h0002, 8'h33); bus_wr(16'h0003, 8'h44);
    bus_rd(16'h0002, rd); chk("R2 frac byte2", {24'd0, rd}, 32'h33);
    bus_rd(16'h000F, rd); chk("R2 update addr reads 0", {24'd0, rd}, 32'd0);

    // R3 shadow writes do not reach outputs
    repeat (12) @(posedge clk_i); #1;
    chk("R3 frac_o unchanged", frac_o, 32'd0);

    // R4 wrong code ignored
    r0 = rises;
    bus_wr(16'h000F, 8'h03);
    repeat (12) @(posedge clk_i); #1;
    chk("R4 frac_o after code 0x03", frac_o, 32'd0);
    chk("R4 no holdover", rises, r0);

    // R5 fraction-only commit
    bus_wr(16'h000F, 8'h01);
    @(posedge clk_i); #1;
    chk("R5 not yet applied", frac_o, 32'd0);
    repeat (8) @(posedge clk_i); #1;
    chk("R5 frac applied", frac_o, 32'h44332211);
    chk("R5 no holdover", rises, r0);

    // R6 R7 integer change, default length 4
    bus_wr(16'h0004, 8'h05);
    bus_wr(16'h000F, 8'h01);
    wait_pulse();
    chk("R6 pulse ticks L=4", pulse_ticks, 4);
    chk("R7 load tick L=4", load_at, 2);
    chk("R7 n_o", n_o, 32'd5);

    // R9 zero length acts as one
    bus_wr(16'h0010, 8'h00);
    bus_wr(16'h0008, 8'h02);
    bus_wr(16'h000F, 8'h01);
    wait_pulse();
    chk("R9 pulse ticks L=0", pulse_ticks, 1);
    chk("R9 load tick L=0", load_at, 1);
    chk("R9 mod_o", mod_o, 32'd2);

    // R8 commits during a window are queued, last one wins
    bus_wr(16'h0010, 8'h05);
    r0 = rises;
    bus_wr(16'h0004, 8'h07);
    bus_wr(16'h000F, 8'h01);
    @(posedge holdover_o);
    bus_wr(16'h0004, 8'h08);
    bus_wr(16'h000F, 8'h01);
    bus_wr(16'h0004, 8'h09);
    bus_wr(16'h000F, 8'h01);
    @(negedge holdover_o);
    #1;
    chk("R8 first window value", n_o, 32'd7);
    wait_pulse();
    chk("R8 queued value", n_o, 32'd9);
    chk("R8 two windows", rises - r0, 2);
    chk("R7 load tick L=5", load_at, 3);

    repeat (6) @(posedge clk_i);
    finish_run();
  end
endmodule